// File: doc/BRIEF.md
# Microcode Next-Address Sequencer

This block produces the control-store address of the next microword on every clock of a microcoded processor. The current microword supplies a 9-bit target field, a 4-bit low-bits override, a 3-bit condition selector and an invert bit. The sequencer combines these with the instruction register, three ALU status flags and a repeat-counter-is-zero indication, and registers the result as the new microprogram counter.

The target is built in two steps. First, a target field of zero is replaced by an opcode dispatch address, the zero-extended 8-bit opcode, so opcode entry points occupy words 0 to 255. Second, when the repeat counter is zero and the override field is nonzero, the override replaces the four low bits of the target. This applies to dispatch targets as well. The selected condition, after optional inversion, then chooses between the target and the sequential successor. The sequential successor is the current address plus one, wrapping from 511 to 0.

Top module: `useq_next_addr`

## Requirements
- R1: While `rst_n` is low, the registered address `upc` is 0 after the next rising clock edge.
- R2: With a nonzero target field and a taken branch, `upc` becomes the target field after one clock.
- R3: A target field of 0 selects the dispatch address {1'b0, opcode[7:0]}.
- R4: When `rpt_zero` is 1 and `low_ovr` is nonzero, bits 3:0 of the chosen target (field or dispatch) are replaced by `low_ovr`, and bits 8:4 are kept.
- R5: A `low_ovr` of 0000, or a `rpt_zero` of 0, leaves the target unchanged.
- R6: Condition select 000 is always true, 001 tests `flag_zero`, 010 tests `flag_ovc`, and 011 tests `flag_equal`.
- R7: With `cond_inv` at 1, the sense of the selected condition is inverted, including code 000.
- R8: Condition selects 100 through 111 evaluate false before inversion, whatever the flag values.
- R9: When the final condition is false, `upc` becomes the previous `upc` plus 1, wrapping 511 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Microcycle clock |
| rst_n | input | 1 | Synchronous reset, active low |
| nxt_field | input | 9 | Target field of the current microword; 0 requests opcode dispatch |
| low_ovr | input | 4 | Low-bits override; 0 means none |
| cond_sel | input | 3 | Branch condition selector |
| cond_inv | input | 1 | Inverts the selected condition |
| opcode | input | 8 | Instruction register contents |
| flag_zero | input | 1 | ALU zero status |
| flag_ovc | input | 1 | ALU overflow/carry status |
| flag_equal | input | 1 | ALU equality status |
| rpt_zero | input | 1 | Repeat counter equals zero |
| upc | output | 9 | Registered next control-store address |

## Verification
The bench targets the places where the three address mechanisms interact. In these cases a design that applies the override before dispatch loses the override on opcode entries, and one that ignores `rpt_zero` redirects jumps while a repeat is still running. It drives codes 100 to 111 with every flag set, so that a decoder which wraps or aliases those codes onto real flags branches when it should fall through. It also inverts the always-true code to force a step, and steps from address 511 to check that the successor wraps to 0 instead of dropping the carry into a wider counter.

// File: rtl/useq_pkg.sv
package useq_pkg;

   // Condition selector encodings; codes above COND_EQ are reserved (false)
   typedef enum logic [2:0] {
      COND_ALWAYS = 3'b000,
      COND_ZERO   = 3'b001,
      COND_OVC    = 3'b010,
      COND_EQ     = 3'b011
   } cond_code_e;

   // Number of status flags that condition codes 1..N map onto
   localparam int unsigned NUM_STATUS_FLAGS = 3;

   // Default geometry of the sequencer
   localparam int unsigned DEF_ADDR_W = 9;
   localparam int unsigned DEF_OVR_W  = 4;
   localparam int unsigned DEF_OP_W   = 8;
   localparam int unsigned DEF_COND_W = 3;

endpackage

// File: rtl/useq_target.sv
// Builds the branch target: opcode dispatch on a zero field, then the
// optional low-bit override gated by the repeat-counter-zero indication.
module useq_target #(
   parameter int unsigned ADDR_W = 9,
   parameter int unsigned OVR_W  = 4,
   parameter int unsigned OP_W   = 8
) (
   input  logic [ADDR_W-1:0] field_i,
   input  logic [OVR_W-1:0]  ovr_i,
   input  logic [OP_W-1:0]   opcode_i,
   input  logic              rpt_zero_i,
   output logic [ADDR_W-1:0] target_o
);
   localparam int unsigned PAD_W = ADDR_W - OP_W;

   logic [ADDR_W-1:0] dispatch_addr;
   logic [ADDR_W-1:0] base_addr;
   logic              field_is_zero;
   logic              ovr_active;

   generate
      if (OVR_W >= ADDR_W) begin : g_bad_ovr
         $error("useq_target: OVR_W must be narrower than ADDR_W");
      end
      if (OP_W > ADDR_W) begin : g_bad_op
         $error("useq_target: OP_W must not exceed ADDR_W");
      end
      if (PAD_W == 0) begin : g_dispatch_full
         assign dispatch_addr = opcode_i;
      end else begin : g_dispatch_pad
         assign dispatch_addr = {{PAD_W{1'b0}}, opcode_i};
      end
   endgenerate

   assign field_is_zero = (field_i == '0);
   assign base_addr     = field_is_zero ? dispatch_addr : field_i;
   assign ovr_active    = rpt_zero_i && (ovr_i != '0);

   // Upper bits always pass through; low bits take the override when active
   generate
      for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
         if (b < OVR_W) begin : g_low
            assign target_o[b] = ovr_active ? ovr_i[b] : base_addr[b];
         end else begin : g_high
            assign target_o[b] = base_addr[b];
         end
      end
   endgenerate

endmodule

// File: rtl/useq_cond.sv
// Evaluates the selected branch condition and applies the invert bit.
module useq_cond #(
   parameter int unsigned COND_W    = 3,
   parameter int unsigned NUM_FLAGS = 3
) (
   input  logic [COND_W-1:0]    sel_i,
   input  logic                 inv_i,
   input  logic [NUM_FLAGS-1:0] flags_i,
   output logic                 taken_o
);
   localparam int unsigned NUM_CODES = 1 << COND_W;

   logic [NUM_CODES-1:0] code_true;

   generate
      if (NUM_FLAGS + 1 > NUM_CODES) begin : g_bad_cfg
         $error("useq_cond: too many flags for COND_W");
      end
      for (genvar k = 0; k < NUM_CODES; k++) begin : g_code
         if (k == 0) begin : g_always
            assign code_true[k] = 1'b1;
         end else if (k <= NUM_FLAGS) begin : g_flag
            assign code_true[k] = flags_i[k-1];
         end else begin : g_reserved
            assign code_true[k] = 1'b0;
         end
      end
   endgenerate

   assign taken_o = code_true[sel_i] ^ inv_i;

endmodule

// File: rtl/useq_upc_reg.sv
// Microprogram counter register with sequential successor.
module useq_upc_reg #(
   parameter int unsigned ADDR_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              taken_i,
   input  logic [ADDR_W-1:0] target_i,
   output logic [ADDR_W-1:0] upc_o
);
   logic [ADDR_W-1:0] succ_addr;
   logic [ADDR_W-1:0] next_addr;

   assign succ_addr = upc_o + ADDR_W'(1);

   always_comb begin
      if (taken_i) begin
         next_addr = target_i;
      end else begin
         next_addr = succ_addr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         upc_o <= '0;
      end else begin
         upc_o <= next_addr;
      end
   end

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr #(
   parameter int unsigned ADDR_W = useq_pkg::DEF_ADDR_W,
   parameter int unsigned OVR_W  = useq_pkg::DEF_OVR_W,
   parameter int unsigned OP_W   = useq_pkg::DEF_OP_W,
   parameter int unsigned COND_W = useq_pkg::DEF_COND_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] nxt_field,
   input  logic [OVR_W-1:0]  low_ovr,
   input  logic [COND_W-1:0] cond_sel,
   input  logic              cond_inv,
   input  logic [OP_W-1:0]   opcode,
   input  logic              flag_zero,
   input  logic              flag_ovc,
   input  logic              flag_equal,
   input  logic              rpt_zero,
   output logic [ADDR_W-1:0] upc
);
   localparam int unsigned NFLAG = useq_pkg::NUM_STATUS_FLAGS;

   logic [ADDR_W-1:0] target;
   logic [NFLAG-1:0]  flags;
   logic              taken;

   // Flag order follows the condition code numbering (code 1 -> bit 0)
   assign flags = {flag_equal, flag_ovc, flag_zero};

   useq_target #(
      .ADDR_W (ADDR_W),
      .OVR_W  (OVR_W),
      .OP_W   (OP_W)
   ) u_target (
      .field_i    (nxt_field),
      .ovr_i      (low_ovr),
      .opcode_i   (opcode),
      .rpt_zero_i (rpt_zero),
      .target_o   (target)
   );

   useq_cond #(
      .COND_W    (COND_W),
      .NUM_FLAGS (NFLAG)
   ) u_cond (
      .sel_i   (cond_sel),
      .inv_i   (cond_inv),
      .flags_i (flags),
      .taken_o (taken)
   );

   useq_upc_reg #(
      .ADDR_W (ADDR_W)
   ) u_upc (
      .clk      (clk),
      .rst_n    (rst_n),
      .taken_i  (taken),
      .target_i (target),
      .upc_o    (upc)
   );

endmodule

// File: rtl/useq_next_addr_chk.sv
module useq_next_addr_chk #(
   parameter int unsigned ADDR_W = 9,
   parameter int unsigned OVR_W  = 4,
   parameter int unsigned OP_W   = 8,
   parameter int unsigned COND_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] nxt_field,
   input logic [OVR_W-1:0]  low_ovr,
   input logic [COND_W-1:0] cond_sel,
   input logic              cond_inv,
   input logic [OP_W-1:0]   opcode,
   input logic              flag_zero,
   input logic              flag_ovc,
   input logic              flag_equal,
   input logic              rpt_zero,
   input logic [ADDR_W-1:0] upc
);
   logic plain_jump;
   assign plain_jump = (cond_sel == '0) && !cond_inv;

   assert_reset_zero_R1: assert property (@(posedge clk)
      !rst_n |=> (upc == '0));

   assert_field_jump_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (plain_jump && nxt_field != '0 && low_ovr == '0) |=> (upc == $past(nxt_field)));

   assert_dispatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (plain_jump && nxt_field == '0 && low_ovr == '0)
         |=> (upc == ADDR_W'($past(opcode))));

   assert_override_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (plain_jump && rpt_zero && low_ovr != '0) |=> (upc[OVR_W-1:0] == $past(low_ovr)));

   assert_no_override_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (plain_jump && !rpt_zero && nxt_field != '0) |=> (upc == $past(nxt_field)));

   assert_flag_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cond_inv && nxt_field != '0 && low_ovr == '0 &&
       ((cond_sel == 3'd1 && flag_zero) || (cond_sel == 3'd2 && flag_ovc) ||
        (cond_sel == 3'd3 && flag_equal)))
         |=> (upc == $past(nxt_field)));

   assert_invert_always_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_sel == '0 && cond_inv) |=> (upc == ADDR_W'($past(upc) + 1'b1)));

   assert_reserved_false_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_sel[2] && !cond_inv) |=> (upc == ADDR_W'($past(upc) + 1'b1)));

   assert_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cond_inv && ((cond_sel == 3'd1 && !flag_zero) || (cond_sel == 3'd2 && !flag_ovc) ||
                     (cond_sel == 3'd3 && !flag_equal)))
         |=> (upc == ADDR_W'($past(upc) + 1'b1)));

endmodule

bind useq_next_addr useq_next_addr_chk #(
   .ADDR_W (ADDR_W),
   .OVR_W  (OVR_W),
   .OP_W   (OP_W),
   .COND_W (COND_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .nxt_field  (nxt_field),
   .low_ovr    (low_ovr),
   .cond_sel   (cond_sel),
   .cond_inv   (cond_inv),
   .opcode     (opcode),
   .flag_zero  (flag_zero),
   .flag_ovc   (flag_ovc),
   .flag_equal (flag_equal),
   .rpt_zero   (rpt_zero),
   .upc        (upc)
);

// File: tb/useq_next_addr_tb.sv
module useq_next_addr_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] nxt_field = '0;
   logic [3:0] low_ovr = '0;
   logic [2:0] cond_sel = '0;
   logic       cond_inv = 1'b0;
   logic [7:0] opcode = '0;
   logic       flag_zero = 1'b0;
   logic       flag_ovc = 1'b0;
   logic       flag_equal = 1'b0;
   logic       rpt_zero = 1'b0;
   logic [8:0] upc;

   int n_vec = 0;
   int n_bad = 0;
   logic [8:0] m_upc = '0;
   logic [8:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   useq_next_addr dut_i (
      .clk(clk), .rst_n(rst_n), .nxt_field(nxt_field), .low_ovr(low_ovr),
      .cond_sel(cond_sel), .cond_inv(cond_inv), .opcode(opcode),
      .flag_zero(flag_zero), .flag_ovc(flag_ovc), .flag_equal(flag_equal),
      .rpt_zero(rpt_zero), .upc(upc)
   );

   function automatic logic [8:0] model(input logic [8:0] cur, input logic [8:0] f,
      input logic [3:0] ov, input logic [2:0] cs, input logic inv, input logic [7:0] op,
      input logic z, input logic oc, input logic e, input logic rz);
      logic [8:0] tgt;
      logic       c;
      tgt = (f == 9'd0) ? {1'b0, op} : f;
      if (rz && ov != 4'd0) tgt[3:0] = ov;
      case (cs)
         3'd0: c = 1'b1;
         3'd1: c = z;
         3'd2: c = oc;
         3'd3: c = e;
         default: c = 1'b0;
      endcase
      c = c ^ inv;
      return c ? tgt : cur + 9'd1;
   endfunction

   task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: upc actual %03h expected %03h", tag, act, exp);
      end
   endtask

   // Driver: applies one microword at the falling edge and queues the result
   task automatic step(input string tag, input logic [8:0] f, input logic [3:0] ov,
      input logic [2:0] cs, input logic inv, input logic [7:0] op,
      input logic z, input logic oc, input logic e, input logic rz);
      @(negedge clk);
      nxt_field = f; low_ovr = ov; cond_sel = cs; cond_inv = inv; opcode = op;
      flag_zero = z; flag_ovc = oc; flag_equal = e; rpt_zero = rz;
      m_upc = model(m_upc, f, ov, cs, inv, op, z, oc, e, rz);
      exp_q.push_back(m_upc);
      tag_q.push_back(tag);
   endtask

   // Monitor: compares after each edge that follows a queued microword
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && exp_q.size() > 0) begin
            check(tag_q.pop_front(), upc, exp_q.pop_front());
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      int seed;
      seed = 32'h1234_5678;
      repeat (3) @(posedge clk);
      #1 check("R1 reset", upc, 9'd0);
      @(negedge clk);
      rst_n = 1'b1;
      m_upc = 9'd0;

      step("R2 jump",          9'h123, 4'h0, 3'd0, 1'b0, 8'h00, 0, 0, 0, 0);
      step("R9 zero false",    9'h040, 4'h0, 3'd1, 1'b0, 8'h00, 0, 1, 1, 0);
      step("R6 zero true",     9'h040, 4'h0, 3'd1, 1'b0, 8'h00, 1, 0, 0, 0);
      step("R6 ovc true",      9'h0A5, 4'h0, 3'd2, 1'b0, 8'h00, 0, 1, 0, 0);
      step("R6 equal true",    9'h1F0, 4'h0, 3'd3, 1'b0, 8'h00, 0, 0, 1, 0);
      step("R6 equal false",   9'h010, 4'h0, 3'd3, 1'b0, 8'h00, 1, 1, 0, 0);
      step("R7 inv zero set",  9'h077, 4'h0, 3'd1, 1'b1, 8'h00, 1, 0, 0, 0);
      step("R7 inv zero clr",  9'h077, 4'h0, 3'd1, 1'b1, 8'h00, 0, 0, 0, 0);
      step("R7 inv always",    9'h100, 4'h0, 3'd0, 1'b1, 8'h00, 1, 1, 1, 0);
      step("R3 dispatch",      9'h000, 4'h0, 3'd0, 1'b0, 8'hC3, 0, 0, 0, 0);
      step("R4 override",      9'h150, 4'hA, 3'd0, 1'b0, 8'h00, 0, 0, 0, 1);
      step("R5 rpt busy",      9'h150, 4'hA, 3'd0, 1'b0, 8'h00, 0, 0, 0, 0);
      step("R5 ovr zero",      9'h155, 4'h0, 3'd0, 1'b0, 8'h00, 0, 0, 0, 1);
      step("R4 dispatch ovr",  9'h000, 4'h5, 3'd0, 1'b0, 8'h3F, 0, 0, 0, 1);
      for (int k = 4; k < 8; k++) begin
         step("R8 reserved",   9'h0EE, 4'h0, 3'(k), 1'b0, 8'h00, 1, 1, 1, 0);
      end
      step("R8 reserved inv",  9'h0EE, 4'h0, 3'd5, 1'b1, 8'h00, 0, 0, 0, 0);
      step("R2 jump top",      9'h1FF, 4'h0, 3'd0, 1'b0, 8'h00, 0, 0, 0, 0);
      step("R9 wrap",          9'h0EE, 4'h0, 3'd7, 1'b0, 8'h00, 1, 1, 1, 0);
      for (int i = 0; i < 60; i++) begin
         int r;
         r = $urandom(seed + i);
         step("R6 R7 mixed", 9'(r), 4'(r >> 9), 3'(r >> 13), r[16], 8'(r >> 17),
              r[25], r[26], r[27], r[28]);
      end
      wait (exp_q.size() == 0);
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #1 check("R1 reset again", upc, 9'd0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule